// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Status Flags

The block receives asynchronous serial frames on a single line. Each frame has a start bit, 7 or 8 data bits sent LSB first, an optional even or odd parity bit, and one or two stop bits. A baud-rate enable tick that runs at the oversampling rate (16x by default) times the line. The start bit is confirmed at its midpoint and every later bit is sampled at its midpoint. The received word goes into a data register, and three sticky flags report the result: data ready, framing error and parity error.

Software uses a small register port with read and write strobes. Address 0 returns the data register. Address 1 returns the status register. A flag can only be cleared by a handshake: software must first read it as 1, then write 0 to that bit. While either error flag is set, the receiver does not start a new frame.

Top module: `serial_rx_core`

## Requirements
- R1: A low line seen on an oversampling tick while idle begins a start bit. The start bit is confirmed if the line is still low OVERSAMPLE/2 ticks later. If the line has returned high by then, the frame is abandoned with no register change. Each later bit is sampled OVERSAMPLE ticks after the previous sample.
- R2: Data bits arrive LSB first. With cfg_short_i=1, 7 bits are received and bit 7 of the data register reads 0. With cfg_short_i=0, 8 bits are received.
- R3: With cfg_par_en_i=1, a parity bit follows the data. The parity error flag (status bit 2) is set when the number of 1s in the data and parity bits is odd while cfg_par_odd_i=0, or even while cfg_par_odd_i=1. With parity disabled, no parity bit is expected and none is checked.
- R4: The framing error flag (status bit 1) is set when the first stop bit is sampled as 0.
- R5: With cfg_two_stop_i=1, the value of the second stop bit is ignored. A 0 there raises no error and does not start a new frame.
- R6: A frame with a framing or parity error still writes its word into the data register, but it does not set the data-ready flag.
- R7: While status bit 1 or bit 2 is 1, no new frame is received. The data register and the status register stay unchanged.
- R8: A status flag clears only when 0 is written to its bit after a status read has returned it as 1. Any write to the status register ends the read-as-1 state of all flags. A written 1 never changes a flag.
- R9: After reset, the status register and the data register read 0.
- R10: Driving cfg_en_i low stops reception and leaves all status flags unchanged.
- R11: A frame with no error writes the data register and sets the data-ready flag (status bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling enable, one pulse per tick |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_en_i | input | 1 | Receive enable |
| cfg_short_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop_i | input | 1 | Two stop bits |
| reg_addr_i | input | 1 | 0 = data register, 1 = status register |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe (status register only) |
| reg_wdata_i | input | 3 | Status write data: bit0 data-ready, bit1 framing, bit2 parity |
| reg_rdata_o | output | DATA_W | Read data for the addressed register |

## Verification
The bench builds the block with OVERSAMPLE=8 and DATA_W=8, and pulses the tick every fourth clock, so one bit lasts 32 clocks. These values keep every frame format short, so a single run covers all of them: 7 and 8 data bits, parity off, even and odd, and one or two stop bits. The same run also covers the false-start window of four ticks and the blocked state after an error. The default synchronizer depth keeps the line latency the same as in the default build.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic per;
    logic fer;
  } rx_err_t;

  localparam int FLAG_RDY = 0;
  localparam int FLAG_FER = 1;
  localparam int FLAG_PER = 2;
  localparam int FLAG_W   = 3;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              en_i,
  input  logic              hold_i,
  input  logic              short_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output rx_err_t           err_o
);
  localparam int MID   = OVERSAMPLE / 2;
  localparam int CNT_W = $clog2(OVERSAMPLE + MID);
  localparam int IDX_W = $clog2(DATA_W + 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_acc_q;
  logic [IDX_W-1:0]  last_idx;
  logic              bit_end;

  assign last_idx = short_i ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
  assign bit_end  = (cnt_q == CNT_W'(OVERSAMPLE - 1));
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      par_acc_q <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      err_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!hold_i && !line_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_W'(MID - 1)) begin
              cnt_q     <= '0;
              idx_q     <= '0;
              par_acc_q <= 1'b0;
              state_q   <= line_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt_q     <= '0;
              sh_q      <= {line_i, sh_q[DATA_W-1:1]};
              par_acc_q <= par_acc_q ^ line_i;
              idx_q     <= idx_q + 1'b1;
              if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt_q     <= '0;
              par_acc_q <= par_acc_q ^ line_i;
              state_q   <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_end) begin
              cnt_q     <= '0;
              done_o    <= 1'b1;
              data_o    <= short_i ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;
              err_o.fer <= ~line_i;
              err_o.per <= par_en_i && (par_acc_q != par_odd_i);
              state_q   <= two_stop_i ? ST_STOP2 : ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP2: begin
            // run to the end of the unchecked second stop bit
            if (cnt_q == CNT_W'(OVERSAMPLE + MID - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  rx_err_t           err_i,
  input  logic              sel_status_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              hold_o
);
  logic [FLAG_W-1:0] mark_q;
  logic [FLAG_W-1:0] set_v;
  logic              st_wr;
  logic              st_rd;

  assign st_wr = wr_i && sel_status_i;
  assign st_rd = rd_i && sel_status_i;

  always_comb begin
    set_v           = '0;
    set_v[FLAG_RDY] = done_i && !err_i.fer && !err_i.per;
    set_v[FLAG_FER] = done_i && err_i.fer;
    set_v[FLAG_PER] = done_i && err_i.per;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mark_q <= '0;
    else if (st_wr)  mark_q <= '0;
    else if (st_rd)  mark_q <= mark_q | flags_o;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    logic clr;
    assign clr = st_wr && mark_q[i] && !wdata_i[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[i] <= 1'b0;
      else if (set_v[i]) flags_o[i] <= 1'b1;
      else if (clr)      flags_o[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (done_i) data_o <= data_i;
  end

  assign hold_o = flags_o[FLAG_FER] | flags_o[FLAG_PER];
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              cfg_en_i,
  input  logic              cfg_short_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_two_stop_i,
  input  logic              reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic              line_s;
  logic              busy;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  rx_err_t           fr_err;
  logic [DATA_W-1:0] data_q;
  logic [FLAG_W-1:0] flags;
  logic              hold;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  serial_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line_s),
    .en_i      (cfg_en_i),
    .hold_i    (hold),
    .short_i   (cfg_short_i),
    .par_en_i  (cfg_par_en_i),
    .par_odd_i (cfg_par_odd_i),
    .two_stop_i(cfg_two_stop_i),
    .busy_o    (busy),
    .done_o    (fr_done),
    .data_o    (fr_data),
    .err_o     (fr_err)
  );

  serial_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (fr_done),
    .data_i      (fr_data),
    .err_i       (fr_err),
    .sel_status_i(reg_addr_i),
    .rd_i        (reg_rd_i),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .data_o      (data_q),
    .flags_o     (flags),
    .hold_o      (hold)
  );

  assign reg_rdata_o = reg_addr_i ? {{(DATA_W-FLAG_W){1'b0}}, flags} : data_q;
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       busy_i,
  input logic       done_i,
  input logic       fer_i,
  input logic       per_i,
  input logic [2:0] flags_i,
  input logic       wr_i,
  input logic       sel_i,
  input logic [2:0] wdata_i
);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[1] || flags_i[2]) && !busy_i |=> !busy_i);

  p_rdy_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[0]) |-> $past(done_i && !fer_i && !per_i));

  p_err_no_rdy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && (fer_i || per_i) && !(wr_i && sel_i) |=> $stable(flags_i[0]));

  p_fer_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[1]) |-> $past(done_i && fer_i));

  p_per_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[2]) |-> $past(done_i && per_i));

  p_fer_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_i[1]) |-> $past(wr_i && sel_i && !wdata_i[1]));

  p_per_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_i[2]) |-> $past(wr_i && sel_i && !wdata_i[2]));

  p_rdy_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_i[0]) |-> $past(wr_i && sel_i && !wdata_i[0]));

  p_en_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !done_i && !(wr_i && sel_i) |=> $stable(flags_i));
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (cfg_en_i),
  .busy_i (busy),
  .done_i (fr_done),
  .fer_i  (fr_err.fer),
  .per_i  (fr_err.per),
  .flags_i(flags),
  .wr_i   (reg_wr_i),
  .sel_i  (reg_addr_i),
  .wdata_i(reg_wdata_i)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  localparam int OS      = 8;
  localparam int TDIV    = 4;
  localparam int BIT_CLK = OS * TDIV;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       cfg_en_i = 1'b1;
  logic       cfg_short_i = 1'b0;
  logic       cfg_par_en_i = 1'b0;
  logic       cfg_par_odd_i = 1'b0;
  logic       cfg_two_stop_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [2:0] reg_wdata_i = 3'b0;
  logic [7:0] reg_rdata_o;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;

  typedef struct {
    logic [7:0] data;
    logic [7:0] status;
    string      tag;
  } exp_t;
  exp_t q[$];

  serial_rx_core #(.OVERSAMPLE(OS), .DATA_W(8), .SYNC_STAGES(2)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    tcnt   <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick_i <= (tcnt == TDIV - 1);
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic reg_read(input logic a, output logic [7:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    reg_rd_i   = 1'b1;
    #1 v = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] wd);
    @(negedge clk_i);
    reg_addr_i  = 1'b1;
    reg_wr_i    = 1'b1;
    reg_wdata_i = wd;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic clear_flags();
    logic [7:0] v;
    reg_read(1'b1, v);
    reg_write(3'b000);
  endtask

  task automatic hold_bit(input logic b);
    rxd_i = b;
    repeat (BIT_CLK) @(negedge clk_i);
  endtask

  // driver: sends a frame with the current config, pushes the expected result
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic stop1,
                            input logic stop2, input logic [7:0] exp_d,
                            input logic [7:0] exp_s, input string tag);
    int   n;
    logic ones;
    n    = cfg_short_i ? 7 : 8;
    ones = 1'b0;
    @(negedge clk_i);
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) begin
      ones ^= d[i];
      hold_bit(d[i]);
    end
    if (cfg_par_en_i) hold_bit(ones ^ cfg_par_odd_i ^ bad_par);
    hold_bit(stop1);
    if (cfg_two_stop_i) hold_bit(stop2);
    hold_bit(1'b1);
    hold_bit(1'b1);
    hold_bit(1'b1);
    q.push_back('{exp_d, exp_s, tag});
  endtask

  // monitor: pops the oldest expectation and compares it with the registers
  task automatic monitor_pop();
    exp_t       e;
    logic [7:0] v;
    e = q.pop_front();
    reg_read(1'b0, v);
    chk(v == e.data, {e.tag, " data"}, v, e.data);
    reg_read(1'b1, v);
    chk(v == e.status, {e.tag, " status"}, v, e.status);
  endtask

  task automatic set_cfg(input bit sh, input bit pe, input bit po, input bit ts);
    cfg_short_i    = sh;
    cfg_par_en_i   = pe;
    cfg_par_odd_i  = po;
    cfg_two_stop_i = ts;
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h0, 8'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R9 reset state
    reg_read(1'b0, v); chk(v == 8'h00, "R9 data", v, 8'h00);
    reg_read(1'b1, v); chk(v == 8'h00, "R9 status", v, 8'h00);

    // R1 R2 R11 clean 8N1
    set_cfg(0, 0, 0, 0);
    send_frame(8'hA5, 0, 1'b1, 1'b1, 8'hA5, 8'h01, "R11 R2 8N1");
    monitor_pop();

    // R8 write 1 keeps, write 0 without prior read keeps, read then 0 clears
    reg_write(3'b111);
    reg_write(3'b000);
    reg_read(1'b1, v); chk(v == 8'h01, "R8 no clear without read", v, 8'h01);
    reg_write(3'b111);
    reg_read(1'b1, v); chk(v == 8'h01, "R8 write 1 ignored", v, 8'h01);
    reg_write(3'b000);
    reg_read(1'b1, v); chk(v == 8'h00, "R8 read-1 then write-0", v, 8'h00);

    // R3 even parity good
    set_cfg(0, 1, 0, 0);
    send_frame(8'h3C, 0, 1'b1, 1'b1, 8'h3C, 8'h01, "R3 even ok");
    monitor_pop();
    clear_flags();

    // R3 R6 odd parity bad
    set_cfg(0, 1, 1, 0);
    send_frame(8'h96, 1, 1'b1, 1'b1, 8'h96, 8'h04, "R3 R6 parity error");
    monitor_pop();

    // R7 blocked while error pending
    send_frame(8'h11, 0, 1'b1, 1'b1, 8'h96, 8'h04, "R7 blocked");
    monitor_pop();

    // R10 enable low keeps flags
    cfg_en_i = 1'b0;
    repeat (50) @(negedge clk_i);
    reg_read(1'b1, v); chk(v == 8'h04, "R10 flags kept", v, 8'h04);
    cfg_en_i = 1'b1;
    clear_flags();
    reg_read(1'b1, v); chk(v == 8'h00, "R8 per cleared", v, 8'h00);

    // R4 R6 framing error
    set_cfg(0, 0, 0, 0);
    send_frame(8'hC3, 0, 1'b0, 1'b1, 8'hC3, 8'h02, "R4 R6 framing error");
    monitor_pop();
    clear_flags();

    // R5 second stop bit 0 ignored
    set_cfg(0, 0, 0, 1);
    send_frame(8'h5E, 0, 1'b1, 1'b0, 8'h5E, 8'h01, "R5 second stop ignored");
    monitor_pop();
    clear_flags();

    // R2 R3 seven bits, odd parity
    set_cfg(1, 1, 1, 0);
    send_frame(8'hDA, 0, 1'b1, 1'b1, 8'h5A, 8'h01, "R2 R3 7O1");
    monitor_pop();
    clear_flags();

    // R1 false start rejected
    @(negedge clk_i);
    rxd_i = 1'b0;
    repeat (2 * TDIV) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk_i);
    reg_read(1'b1, v); chk(v == 8'h00, "R1 false start status", v, 8'h00);
    reg_read(1'b0, v); chk(v == 8'h5A, "R1 false start data", v, 8'h5A);

    // R1 R11 receiver still works afterwards
    set_cfg(0, 1, 0, 1);
    send_frame(8'h00, 0, 1'b1, 1'b1, 8'h00, 8'h01, "R1 R11 8E2");
    monitor_pop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule